// File: doc/BRIEF.md
# Packed SIMD integer ALU

This block is a lane-parallel integer datapath for a 32-bit word. Each operand word is viewed either as two 16-bit halfword lanes or as four 8-bit byte lanes. Every lane is computed on its own, so no carry or borrow crosses a lane boundary. A 4-bit operation code selects one of fourteen functions: lane add and subtract, signed halfword absolute value and maximum, unsigned byte maximum and minimum, byte and halfword packing shuffles, AND with an inverted second operand, and one step of a restoring long division.

The result path can be purely combinational, or it can end in an output register (the default). The registered variant captures the result whenever the input valid is high and flags it with an output valid one cycle later. Operation codes outside the defined set give a zero result and raise an illegal-operation output. Operand A is called `a` and operand B is called `b` below. Halfword lane 1 is bits [31:16] and lane 0 is bits [15:0].

Top module: `simd_alu`

## Requirements
- R1: Code 0 adds the two halfword lanes separately and drops the carry out of lane 0. 0x002137E1 + 0x039AE4B8 gives 0x03BB1C99, and 0xFFFFFFFF + 0x00010001 gives 0x00000000.
- R2: Code 1 adds the four byte lanes, each modulo 256. 0xFF684E3D + 0x3FF6F105 gives 0x3E5E3F42.
- R3: Code 2 subtracts b from a in each halfword lane, and a borrow stays inside its lane. 0x00003333 - 0x00005151 gives 0x0000E1E2.
- R4: Code 3 returns the absolute value of each signed halfword of a. 0xFF684E3D gives 0x00984E3D, and a lane holding 0x8000 gives 0x7FFF, so bit 15 of each lane is always 0.
- R5: Code 4 picks the signed maximum in each halfword lane. 0x3789F23A and 0x04B84975 give 0x37894975.
- R6: Code 5 picks the unsigned maximum in each byte lane, and code 6 picks the unsigned minimum. For 0x3789F23A and 0x04B84975 these give 0x37B8F275 and 0x0489493A.
- R7: Byte packing. Code 7 gives {a[31:24], a[15:8], b[31:24], b[15:8]}, and code 8 gives {a[23:16], a[7:0], b[23:16], b[7:0]}. For the R5 operands these are 0x37F20449 and 0x893AB875.
- R8: Halfword packing. Code 9 gives {a[31:16], b[15:0]}, code 10 gives {a[31:16], b[31:16]} and code 11 gives {a[15:0], b[15:0]}. For the R5 operands these are 0x37894975, 0x378904B8 and 0xF23A4975.
- R9: Code 12 returns a AND NOT b. 0x195721AB and 0x081C17E6 give 0x11432009.
- R10: Code 13 is a division step. If a >= b as unsigned numbers, the result is ((a-b) << 1) | 1, otherwise it is a << 1. 0x00021A31 and 0x0001F63F give 0x000047E5, 5 and 9 give 0x0000000A, and 7 and 7 give 0x00000001.
- R11: Codes 14 and 15 give a zero result with illegal_op = 1. Every code from 0 to 13 gives illegal_op = 0.
- R12: In the registered variant, res_valid equals in_valid delayed by one cycle. result and illegal_op load only when in_valid is 1 and otherwise hold their value.
- R13: While rst is high, result, res_valid and illegal_op are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation code are valid |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | Operand a |
| opnd_b | input | 32 | Operand b |
| res_valid | output | 1 | Result is valid |
| result | output | 32 | Lane result |
| illegal_op | output | 1 | Operation code was undefined |

## Verification
The assertions check, on every cycle, the one-cycle valid delay, the zero result with the illegal flag for undefined codes, the lane-0 halfword sum without carry-in, the AND-with-inverse result, the cleared sign bits after an absolute value, and that byte 0 of an unsigned maximum is not below either input byte. The bench scenarios show the exact values for every other operation. These include the packing shuffles, the 0x8000 absolute-value corner, both branches of the division step and its equal-operand boundary, that results hold while in_valid is low, and the reset state. A pseudo-random sweep over all sixteen codes compares each result with a behavioural model.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_ADD_H   = 4'd0,
    OP_ADD_B   = 4'd1,
    OP_SUB_H   = 4'd2,
    OP_ABS_H   = 4'd3,
    OP_MAXS_H  = 4'd4,
    OP_MAXU_B  = 4'd5,
    OP_MINU_B  = 4'd6,
    OP_PKHI_B  = 4'd7,
    OP_PKLO_B  = 4'd8,
    OP_PK_HL   = 4'd9,
    OP_PK_HH   = 4'd10,
    OP_PK_LL   = 4'd11,
    OP_ANDINV  = 4'd12,
    OP_DIVSTEP = 4'd13
  } alu_op_e;

  localparam logic [3:0] OP_LAST = 4'd13;

endpackage

// File: rtl/simd_half_unit.sv
module simd_half_unit
  import simd_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  localparam int NLANE = WIDTH / HALF_W;
  localparam logic [HALF_W-1:0] MOST_NEG = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] MOST_POS = {1'b0, {(HALF_W-1){1'b1}}};

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [HALF_W-1:0] la, lb, ly;
    assign la = a[i*HALF_W +: HALF_W];
    assign lb = b[i*HALF_W +: HALF_W];

    always_comb begin
      ly = '0;
      case (op)
        OP_ADD_H:  ly = la + lb;
        OP_SUB_H:  ly = la - lb;
        OP_ABS_H: begin
          if (la == MOST_NEG)        ly = MOST_POS;
          else if (la[HALF_W-1])     ly = -la;
          else                       ly = la;
        end
        OP_MAXS_H: ly = ($signed(la) > $signed(lb)) ? la : lb;
        default:   ly = '0;
      endcase
    end

    assign y[i*HALF_W +: HALF_W] = ly;
  end
endmodule

// File: rtl/simd_byte_unit.sv
module simd_byte_unit
  import simd_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  localparam int NLANE = WIDTH / BYTE_W;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [BYTE_W-1:0] la, lb, ly;
    logic              a_ge_b;
    assign la     = a[i*BYTE_W +: BYTE_W];
    assign lb     = b[i*BYTE_W +: BYTE_W];
    assign a_ge_b = (la >= lb);

    always_comb begin
      ly = '0;
      case (op)
        OP_ADD_B:  ly = la + lb;
        OP_MAXU_B: ly = a_ge_b ? la : lb;
        OP_MINU_B: ly = a_ge_b ? lb : la;
        default:   ly = '0;
      endcase
    end

    assign y[i*BYTE_W +: BYTE_W] = ly;
  end
endmodule

// File: rtl/simd_pack_unit.sv
module simd_pack_unit
  import simd_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  localparam int NHALF = WIDTH / HALF_W;
  localparam int HWORD = WIDTH / 2;

  // Upper or lower byte of every halfword, gathered per operand
  logic [HWORD-1:0] a_hib, a_lob, b_hib, b_lob;

  for (genvar j = 0; j < NHALF; j++) begin : g_gather
    assign a_hib[j*BYTE_W +: BYTE_W] = a[j*HALF_W + BYTE_W +: BYTE_W];
    assign a_lob[j*BYTE_W +: BYTE_W] = a[j*HALF_W +: BYTE_W];
    assign b_hib[j*BYTE_W +: BYTE_W] = b[j*HALF_W + BYTE_W +: BYTE_W];
    assign b_lob[j*BYTE_W +: BYTE_W] = b[j*HALF_W +: BYTE_W];
  end

  always_comb begin
    y = '0;
    case (op)
      OP_PKHI_B: y = {a_hib, b_hib};
      OP_PKLO_B: y = {a_lob, b_lob};
      OP_PK_HL:  y = {a[WIDTH-1:HWORD], b[HWORD-1:0]};
      OP_PK_HH:  y = {a[WIDTH-1:HWORD], b[WIDTH-1:HWORD]};
      OP_PK_LL:  y = {a[HWORD-1:0],     b[HWORD-1:0]};
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/simd_misc_unit.sv
module simd_misc_unit
  import simd_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  // Extra top bit carries the borrow of the trial subtraction
  logic [WIDTH:0] trial;
  logic           borrow;

  assign trial  = {1'b0, a} - {1'b0, b};
  assign borrow = trial[WIDTH];

  always_comb begin
    y = '0;
    case (op)
      OP_ANDINV:  y = a & ~b;
      OP_DIVSTEP: y = borrow ? {a[WIDTH-2:0], 1'b0}
                             : {trial[WIDTH-2:0], 1'b1};
      default:    y = '0;
    endcase
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int WIDTH   = 32,  // multiple of 32
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             res_valid,
  output logic [WIDTH-1:0] result,
  output logic             illegal_op
);
  alu_op_e          op_e;
  logic [WIDTH-1:0] half_y, byte_y, pack_y, misc_y;
  logic [WIDTH-1:0] nxt_result;
  logic             nxt_illegal;

  assign op_e = alu_op_e'(op_sel);

  simd_half_unit #(.WIDTH(WIDTH)) half_u (
    .op(op_e), .a(opnd_a), .b(opnd_b), .y(half_y));

  simd_byte_unit #(.WIDTH(WIDTH)) byte_u (
    .op(op_e), .a(opnd_a), .b(opnd_b), .y(byte_y));

  simd_pack_unit #(.WIDTH(WIDTH)) pack_u (
    .op(op_e), .a(opnd_a), .b(opnd_b), .y(pack_y));

  simd_misc_unit #(.WIDTH(WIDTH)) misc_u (
    .op(op_e), .a(opnd_a), .b(opnd_b), .y(misc_y));

  assign nxt_illegal = (op_sel > OP_LAST);

  always_comb begin
    nxt_result = '0;
    case (op_e)
      OP_ADD_H, OP_SUB_H, OP_ABS_H, OP_MAXS_H:       nxt_result = half_y;
      OP_ADD_B, OP_MAXU_B, OP_MINU_B:                nxt_result = byte_y;
      OP_PKHI_B, OP_PKLO_B, OP_PK_HL, OP_PK_HH,
      OP_PK_LL:                                      nxt_result = pack_y;
      OP_ANDINV, OP_DIVSTEP:                         nxt_result = misc_y;
      default:                                       nxt_result = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_valid  <= 1'b0;
        result     <= '0;
        illegal_op <= 1'b0;
      end else begin
        res_valid <= in_valid;
        if (in_valid) begin
          result     <= nxt_result;
          illegal_op <= nxt_illegal;
        end
      end
    end
  end else begin : g_comb
    assign res_valid  = in_valid & ~rst;
    assign result     = rst ? '0 : nxt_result;
    assign illegal_op = nxt_illegal & ~rst;
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
  import simd_alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             res_valid,
  input logic [WIDTH-1:0] result,
  input logic             illegal_op
);
  if (REG_OUT) begin : g_seq
    assert_valid_rise_R12: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);

    assert_valid_fall_R12: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !res_valid);

    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel > OP_LAST) |=> (illegal_op && result == '0));

    assert_legal_flag_R11: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel <= OP_LAST) |=> !illegal_op);

    assert_lane0_sum_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_ADD_H) |=>
        result[15:0] == 16'($past(opnd_a[15:0]) + $past(opnd_b[15:0])));

    assert_andinv_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_ANDINV) |=>
        result == ($past(opnd_a) & ~$past(opnd_b)));

    assert_abs_sign_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_ABS_H) |=> (!result[15] && !result[31]));

    assert_umax_byte0_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_MAXU_B) |=>
        (result[7:0] >= $past(opnd_a[7:0]) && result[7:0] >= $past(opnd_b[7:0])));
  end
endmodule

bind simd_alu simd_alu_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/simd_alu_tb_top.sv
module simd_alu_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_sel = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         res_valid;
  logic [W-1:0] result;
  logic         illegal_op;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  simd_alu #(.WIDTH(W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .result(result), .illegal_op(illegal_op));

  // Behavioural model written from the requirement list
  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    case (op)
      4'd0: for (int h = 0; h < 2; h++) r[h*16 +: 16] = a[h*16 +: 16] + b[h*16 +: 16];
      4'd1: for (int k = 0; k < 4; k++) r[k*8 +: 8] = a[k*8 +: 8] + b[k*8 +: 8];
      4'd2: for (int h = 0; h < 2; h++) r[h*16 +: 16] = a[h*16 +: 16] - b[h*16 +: 16];
      4'd3: for (int h = 0; h < 2; h++) begin
              int v = $signed(a[h*16 +: 16]);
              if (v < 0) v = -v;
              if (v > 32767) v = 32767;
              r[h*16 +: 16] = 16'(v);
            end
      4'd4: for (int h = 0; h < 2; h++) begin
              int va = $signed(a[h*16 +: 16]);
              int vb = $signed(b[h*16 +: 16]);
              r[h*16 +: 16] = (va > vb) ? a[h*16 +: 16] : b[h*16 +: 16];
            end
      4'd5: for (int k = 0; k < 4; k++) r[k*8 +: 8] = (a[k*8 +: 8] > b[k*8 +: 8]) ? a[k*8 +: 8] : b[k*8 +: 8];
      4'd6: for (int k = 0; k < 4; k++) r[k*8 +: 8] = (a[k*8 +: 8] < b[k*8 +: 8]) ? a[k*8 +: 8] : b[k*8 +: 8];
      4'd7:  r = {a[31:24], a[15:8], b[31:24], b[15:8]};
      4'd8:  r = {a[23:16], a[7:0], b[23:16], b[7:0]};
      4'd9:  r = {a[31:16], b[15:0]};
      4'd10: r = {a[31:16], b[31:16]};
      4'd11: r = {a[15:0], b[15:0]};
      4'd12: r = a & ~b;
      4'd13: r = (a >= b) ? (((a - b) << 1) | 32'd1) : (a << 1);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // One valid operation: drive at negedge, result registered at next posedge
  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp, input logic exp_ill);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " res_valid"}, 32'(res_valid), 32'd1);
    chk({tag, " result"}, result, exp);
    chk({tag, " illegal_op"}, 32'(illegal_op), 32'(exp_ill));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 reset result", result, 32'h0);
    chk("R13 reset res_valid", 32'(res_valid), 32'd0);
    chk("R13 reset illegal_op", 32'(illegal_op), 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_half_add;
    run_op("R1 halfword add", 4'd0, 32'h002137E1, 32'h039AE4B8, 32'h03BB1C99, 1'b0);
    run_op("R1 halfword add wrap", 4'd0, 32'hFFFFFFFF, 32'h00010001, 32'h00000000, 1'b0);
  endtask

  task automatic t_byte_add;
    run_op("R2 byte add", 4'd1, 32'hFF684E3D, 32'h3FF6F105, 32'h3E5E3F42, 1'b0);
  endtask

  task automatic t_half_sub;
    run_op("R3 halfword sub", 4'd2, 32'h00003333, 32'h00005151, 32'h0000E1E2, 1'b0);
  endtask

  task automatic t_abs;
    run_op("R4 abs", 4'd3, 32'hFF684E3D, 32'h0, 32'h00984E3D, 1'b0);
    run_op("R4 abs most negative", 4'd3, 32'h80000001, 32'h0, 32'h7FFF0001, 1'b0);
  endtask

  task automatic t_smax;
    run_op("R5 signed max", 4'd4, 32'h3789F23A, 32'h04B84975, 32'h37894975, 1'b0);
  endtask

  task automatic t_umaxmin;
    run_op("R6 unsigned max", 4'd5, 32'h3789F23A, 32'h04B84975, 32'h37B8F275, 1'b0);
    run_op("R6 unsigned min", 4'd6, 32'h3789F23A, 32'h04B84975, 32'h0489493A, 1'b0);
  endtask

  task automatic t_pack_bytes;
    run_op("R7 pack high bytes", 4'd7, 32'h3789F23A, 32'h04B84975, 32'h37F20449, 1'b0);
    run_op("R7 pack low bytes", 4'd8, 32'h3789F23A, 32'h04B84975, 32'h893AB875, 1'b0);
  endtask

  task automatic t_pack_halves;
    run_op("R8 pack high-low", 4'd9, 32'h3789F23A, 32'h04B84975, 32'h37894975, 1'b0);
    run_op("R8 pack high-high", 4'd10, 32'h3789F23A, 32'h04B84975, 32'h378904B8, 1'b0);
    run_op("R8 pack low-low", 4'd11, 32'h3789F23A, 32'h04B84975, 32'hF23A4975, 1'b0);
  endtask

  task automatic t_andinv;
    run_op("R9 and-invert", 4'd12, 32'h195721AB, 32'h081C17E6, 32'h11432009, 1'b0);
  endtask

  task automatic t_divstep;
    run_op("R10 divstep subtract", 4'd13, 32'h00021A31, 32'h0001F63F, 32'h000047E5, 1'b0);
    run_op("R10 divstep shift only", 4'd13, 32'd5, 32'd9, 32'h0000000A, 1'b0);
    run_op("R10 divstep equal", 4'd13, 32'd7, 32'd7, 32'h00000001, 1'b0);
  endtask

  task automatic t_illegal;
    run_op("R11 code 14", 4'd14, 32'h12345678, 32'h9ABCDEF0, 32'h0, 1'b1);
    run_op("R11 code 15", 4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 1'b1);
  endtask

  task automatic t_hold;
    run_op("R12 load", 4'd12, 32'hF0F0F0F0, 32'h0000FFFF, 32'hF0F00000, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; op_sel = 4'd15; opnd_a = 32'hDEADBEEF; opnd_b = 32'h1;
    @(posedge clk);
    @(negedge clk);
    chk("R12 idle res_valid", 32'(res_valid), 32'd0);
    chk("R12 idle result held", result, 32'hF0F00000);
    chk("R12 idle illegal held", 32'(illegal_op), 32'd0);
    in_valid = 1'b1; op_sel = 4'd0; opnd_a = 32'h1; opnd_b = 32'h1;
    #5;
    chk("R12 no early valid", 32'(res_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 valid after one cycle", 32'(res_valid), 32'd1);
    chk("R12 new result", result, 32'h00000002);
  endtask

  task automatic t_sweep;
    logic [31:0] s = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [3:0]  op;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      a = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      b = s;
      op = 4'(n % 16);
      if (n % 7 == 0) a[15:0] = 16'h8000;
      run_op($sformatf("R11 sweep op=%0d", op), op, a, b, model(op, a, b), op > 4'd13);
    end
  endtask

  initial begin
    t_reset();
    t_half_add();
    t_byte_add();
    t_half_sub();
    t_abs();
    t_smax();
    t_umaxmin();
    t_pack_bytes();
    t_pack_halves();
    t_andinv();
    t_divstep();
    t_illegal();
    t_hold();
    t_sweep();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule